// File: doc/BRIEF.md
# Circular Return Address Stack

This block predicts where a function return will go. The fetch unit pushes the return address when it sees a call. When it sees a return, it reads the address at the top of the stack as the predicted target, which is always treated as taken, and pops that entry. The caller's decode logic says which instructions are calls and which are returns. This block only keeps the addresses in order.

The stack never refuses a push. When every slot is in use, a new push overwrites the oldest entry and the top pointer wraps around. The number of entries that can be popped stays at the depth. The outermost frames are rarely returned to while deep code runs, so losing them costs little. A push and a pop in the same cycle (a return followed at once by a call) replace the top entry in place.

Top module: `ret_addr_stack`

## Requirements
- R1: While rst_ni is low, and after it rises with no operation yet performed, valid_o is 0 and top_o is 0.
- R2: A push alone makes valid_o 1 and top_o equal to the pushed address at the first clock edge after push_i is sampled.
- R3: A pop alone on a non-empty stack removes the top entry. After that edge, top_o shows the entry pushed just before it, or valid_o drops to 0 if the popped entry was the last one.
- R4: The count of entries that can be popped saturates at DEPTH. After DEPTH+k pushes, exactly DEPTH pops return valid entries, newest first, and the oldest k addresses are lost.
- R5: A pop alone on an empty stack has no effect. valid_o stays 0, and a following push and pop behave exactly as on a freshly reset stack.
- R6: A push and a pop in the same cycle on a non-empty stack replace the top entry with the pushed address and leave the entry count unchanged.
- R7: A push and a pop in the same cycle on an empty stack act as a push alone.
- R8: When valid_o is 0, top_o is driven to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| push_i | input | 1 | Push request (call seen) |
| push_addr_i | input | AW | Return address to push |
| pop_i | input | 1 | Pop request (return seen) |
| top_o | output | AW | Predicted return target (top entry) |
| valid_o | output | 1 | Stack holds at least one entry |

## Verification
A top pointer that is off by one shows on top_o at the edge after the next push or pop, as an older or stale address. A wrong entry count shows only later, as valid_o staying high for one pop too many or dropping one pop too early. The count fault is therefore exposed by draining the stack to empty after overfilling it, after a pop on an empty stack, and after combined push and pop cycles. A write to the wrong slot during a wrapped push shows up one or more pops later, when the overwritten slot reaches the top.

// File: rtl/ras_pkg.sv
package ras_pkg;
  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_PUSH = 2'd1,
    OP_POP  = 2'd2,
    OP_SWAP = 2'd3
  } ras_op_e;

  // empty stack: a lone pop is dropped, push+pop degrades to a push
  function automatic ras_op_e ras_decode(input logic push, input logic pop, input logic empty);
    ras_op_e op;
    unique case ({push, pop})
      2'b10:   op = OP_PUSH;
      2'b01:   op = empty ? OP_IDLE : OP_POP;
      2'b11:   op = empty ? OP_PUSH : OP_SWAP;
      default: op = OP_IDLE;
    endcase
    return op;
  endfunction
endpackage

// File: rtl/ras_ctrl.sv
module ras_ctrl
  import ras_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic          pop_i,
  output logic          wr_en_o,
  output logic [PW-1:0] wr_idx_o,
  output logic [PW-1:0] rd_idx_o,
  output logic [CW-1:0] cnt_o,
  output logic          valid_o
);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [PW-1:0] ptr_q, ptr_d, top_idx, nxt_idx;
  logic [CW-1:0] cnt_q, cnt_d;
  ras_op_e       op;

  assign op      = ras_decode(push_i, pop_i, cnt_q == '0);
  assign top_idx = (ptr_q == '0) ? LAST : ptr_q - 1'b1;
  assign nxt_idx = (ptr_q == LAST) ? '0 : ptr_q + 1'b1;

  always_comb begin
    ptr_d = ptr_q;
    cnt_d = cnt_q;
    unique case (op)
      OP_PUSH: begin
        ptr_d = nxt_idx;
        if (cnt_q != FULL) cnt_d = cnt_q + 1'b1;
      end
      OP_POP: begin
        ptr_d = top_idx;
        cnt_d = cnt_q - 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
      cnt_q <= '0;
    end else begin
      ptr_q <= ptr_d;
      cnt_q <= cnt_d;
    end
  end

  assign wr_en_o  = (op == OP_PUSH) || (op == OP_SWAP);
  assign wr_idx_o = (op == OP_SWAP) ? top_idx : ptr_q;
  assign rd_idx_o = top_idx;
  assign cnt_o    = cnt_q;
  assign valid_o  = (cnt_q != '0);
endmodule

// File: rtl/ras_store.sv
module ras_store #(
  parameter int AW    = 32,
  parameter int DEPTH = 8,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk_i,
  input  logic          wr_en_i,
  input  logic [PW-1:0] wr_idx_i,
  input  logic [AW-1:0] wr_data_i,
  input  logic [PW-1:0] rd_idx_i,
  output logic [AW-1:0] rd_data_o
);
  logic [AW-1:0] mem [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk_i) begin
      if (wr_en_i && (wr_idx_i == PW'(i))) mem[i] <= wr_data_i;
    end
  end

  assign rd_data_o = mem[rd_idx_i];
endmodule

// File: rtl/ret_addr_stack.sv
module ret_addr_stack #(
  parameter int AW    = 32,
  parameter int DEPTH = 8,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [AW-1:0] push_addr_i,
  input  logic          pop_i,
  output logic [AW-1:0] top_o,
  output logic          valid_o
);
  logic          wr_en;
  logic [PW-1:0] wr_idx, rd_idx;
  logic [CW-1:0] occ;
  logic [AW-1:0] rd_data;
  logic          has_entry;

  ras_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .push_i   (push_i),
    .pop_i    (pop_i),
    .wr_en_o  (wr_en),
    .wr_idx_o (wr_idx),
    .rd_idx_o (rd_idx),
    .cnt_o    (occ),
    .valid_o  (has_entry)
  );

  ras_store #(.AW(AW), .DEPTH(DEPTH)) u_store (
    .clk_i     (clk_i),
    .wr_en_i   (wr_en),
    .wr_idx_i  (wr_idx),
    .wr_data_i (push_addr_i),
    .rd_idx_i  (rd_idx),
    .rd_data_o (rd_data)
  );

  assign valid_o = has_entry;
  assign top_o   = has_entry ? rd_data : '0;
endmodule

// File: rtl/ras_chk.sv
module ras_chk #(
  parameter int AW    = 32,
  parameter int DEPTH = 8,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          push_i,
  input logic [AW-1:0] push_addr_i,
  input logic          pop_i,
  input logic [AW-1:0] top_o,
  input logic          valid_o,
  input logic [CW-1:0] cnt_i
);
  a_r2_push_shows_top: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i && !pop_i |=> valid_o && top_o == $past(push_addr_i));

  a_r3_last_pop_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i && !push_i && cnt_i == CW'(1) |=> !valid_o);

  a_r4_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_i <= CW'(DEPTH));

  a_r4_saturate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i && !pop_i && cnt_i == CW'(DEPTH) |=> cnt_i == CW'(DEPTH));

  a_r5_empty_pop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i && !push_i && !valid_o |=> !valid_o && $stable(cnt_i));

  a_r6_swap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i && pop_i && valid_o |=> valid_o && $stable(cnt_i) && top_o == $past(push_addr_i));

  a_r7_swap_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i && pop_i && !valid_o |=> cnt_i == CW'(1));

  a_r8_zero_top: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> top_o == '0);
endmodule

bind ret_addr_stack ras_chk #(.AW(AW), .DEPTH(DEPTH)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .push_i      (push_i),
  .push_addr_i (push_addr_i),
  .pop_i       (pop_i),
  .top_o       (top_o),
  .valid_o     (valid_o),
  .cnt_i       (occ)
);

// File: tb/sim_ret_addr_stack.sv
module sim_ret_addr_stack;
  localparam int CLK_T = 10;
  localparam int AW    = 16;
  localparam int DEPTH = 4;

  typedef struct packed {
    logic          push;
    logic          pop;
    logic [AW-1:0] addr;
    logic          exp_v;
    logic [AW-1:0] exp_top;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b0, 16'h1001, 1'b1, 16'h1001}, // R2
    '{1'b1, 1'b0, 16'h1002, 1'b1, 16'h1002}, // R2
    '{1'b0, 1'b1, 16'h0000, 1'b1, 16'h1001}, // R3
    '{1'b1, 1'b0, 16'h1003, 1'b1, 16'h1003}, // R2
    '{1'b1, 1'b1, 16'h1004, 1'b1, 16'h1004}, // R6
    '{1'b0, 1'b1, 16'h0000, 1'b1, 16'h1001}, // R6 count unchanged
    '{1'b0, 1'b1, 16'h0000, 1'b0, 16'h0000}, // R3 R8
    '{1'b0, 1'b1, 16'h0000, 1'b0, 16'h0000}, // R5
    '{1'b1, 1'b1, 16'h1005, 1'b1, 16'h1005}, // R7
    '{1'b0, 1'b1, 16'h0000, 1'b0, 16'h0000}  // R7 one entry
  };

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          push = 1'b0;
  logic          pop = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [AW-1:0] top;
  logic          valid;
  int            total = 0;
  int            bad = 0;

  always #(CLK_T/2) clk = ~clk;

  ret_addr_stack #(.AW(AW), .DEPTH(DEPTH)) u0 (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .push_i      (push),
    .push_addr_i (addr),
    .pop_i       (pop),
    .top_o       (top),
    .valid_o     (valid)
  );

  task automatic check(input string req, input logic ev, input logic [AW-1:0] et);
    total++;
    if (valid !== ev || top !== et) begin
      bad++;
      $display("FAIL %s: valid=%0b top=%h expected valid=%0b top=%h", req, valid, top, ev, et);
    end
  endtask

  // drive on falling edge, check just after the next rising edge
  task automatic step(input logic pu, input logic po, input logic [AW-1:0] a);
    @(negedge clk);
    push = pu; pop = po; addr = a;
    @(posedge clk);
    #1;
    push = 1'b0; pop = 1'b0;
  endtask

  initial begin
    #(CLK_T * 3);
    check("R1 in reset", 1'b0, '0);
    @(negedge clk);
    rst_ni = 1'b1;
    @(posedge clk); #1;
    check("R1 after reset", 1'b0, '0);

    for (int i = 0; i < NV; i++) begin
      step(VECS[i].push, VECS[i].pop, VECS[i].addr);
      check($sformatf("vec%0d R2/R3/R5/R6/R7/R8", i), VECS[i].exp_v, VECS[i].exp_top);
    end

    // R4: six pushes into four slots
    for (int i = 1; i <= 6; i++) step(1'b1, 1'b0, AW'(16'h2000 + i));
    check("R4 top after wrap", 1'b1, 16'h2006);
    for (int i = 5; i >= 3; i--) begin
      step(1'b0, 1'b1, '0);
      check("R4 pop order", 1'b1, AW'(16'h2000 + i));
    end
    step(1'b0, 1'b1, '0);
    check("R4 saturated count drains", 1'b0, '0);

    // R5: extra empty pops, then stack must act as fresh
    step(1'b0, 1'b1, '0);
    step(1'b0, 1'b1, '0);
    check("R5 empty pop", 1'b0, '0);
    step(1'b1, 1'b0, 16'h3001);
    check("R5 push after empty pops", 1'b1, 16'h3001);
    step(1'b1, 1'b0, 16'h3002);
    step(1'b0, 1'b1, '0);
    check("R5 pop after empty pops", 1'b1, 16'h3001);
    step(1'b0, 1'b1, '0);
    check("R5 drained", 1'b0, '0);

    // R6 on a full stack
    for (int i = 1; i <= 4; i++) step(1'b1, 1'b0, AW'(16'h4000 + i));
    step(1'b1, 1'b1, 16'h4444);
    check("R6 full swap", 1'b1, 16'h4444);
    step(1'b0, 1'b1, '0);
    check("R6 below swap", 1'b1, 16'h4003);

    // R1: asynchronous reset mid-run
    @(negedge clk);
    rst_ni = 1'b0;
    #1;
    check("R1 async reset", 1'b0, '0);
    @(negedge clk);
    rst_ni = 1'b1;
    step(1'b0, 1'b1, '0);
    check("R1 empty after reset", 1'b0, '0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule